// File: doc/BRIEF.md
# Card Reader Order Sequencer

This block is the control sequencer for a card reader that sits on an I/O channel. The channel issues one of five operations: start, test, test-device, halt or acknowledge. Each operation is answered one clock later with a status word. An accepted start sends the sequencer into its order-fetch state. There it asks the channel for an order byte and checks that the byte is legal. A legal order sets the output stacker and the conversion mode for the card. The card's data movement is handed to an external datapath by a done/error handshake. When the datapath finishes, the card is retired. Retiring a card bumps the chosen stacker's count and takes one card off the hopper. If the channel asks for chaining, the sequencer goes back to fetch another order.

The hopper count is written through a load port. The reader counts as attached, or in automatic state, whenever that count is nonzero. It detaches by itself once the last card is retired. A single interrupt request line is raised when a card ends without chaining and when an order is rejected. Halt and acknowledge clear it.

Top module: `crd_order_ctrl`

## Requirements
- R1: A start operation (op_code 0) taken while idle and attached enters the order-fetch state on the next cycle, and `ord_req` is then high. A start taken while busy or detached changes nothing. Every start returns the test status word, computed as it stood before the operation.
- R2: An order byte taken with `ord_ack` in the fetch state is legal only when all of these hold: bits [7:6] are 00, bits [1:0] are 10, and bits [5:4] are not 10. An illegal byte gives a one-cycle `uen` pulse and a return to idle. A legal byte starts the transfer, shown by `xfer_active`.
- R3: Order bits [5:4] select the stacker: 01 selects stacker index 1, 11 selects index 2, and anything else selects index 0. `stk_sel` shows the index. Each retired card adds one to that stacker's field of `stk_cnt` (index i at bits [i*CNT_W +: CNT_W]). The count wraps to zero on overflow.
- R4: `auto_mode` equals order bit 2 during the transfer. Bit 2 = 1 means translated mode and bit 2 = 0 means binary mode.
- R5: `dp_done` during transfer moves to the end state. The following cycle ends the card. On that edge `chan_end` pulses for one cycle and the hopper count drops by one. When the hopper reaches zero the reader is detached: the automatic bit is clear and starts are refused.
- R6: If `chain_in` is high when a card ends, the sequencer goes back to the fetch state (`ord_req` high). Otherwise it goes idle.
- R7: A halt (op_code 3) always clears `irq`. While busy, a halt also returns to idle at once and pulses `uen`. While idle, a halt produces no `uen`.
- R8: The test status word (op_code 1) is laid out as follows. Bit 7 is set when attached. While busy, bits 6 and 5 (controller busy, device busy) are set and bits [9:8] hold condition code 2 (binary 10). All other bits are zero.
- R9: The test-device word (op_code 2) depends on the attached state. When attached, it is the unit status byte in bits [7:0]: bit 3 is set if `dp_err` came with `dp_done` on a card since the last accepted start. When detached, the word is 0x0200 (condition code 2).
- R10: An acknowledge (op_code 4) returns a zero word and clears `irq`. `irq` is set when a card ends without chaining and when an order is rejected. A clear on the same edge wins over a set.
- R11: `hop_load` writes `hop_value` into the hopper count on the next edge, and the write wins over a decrement on the same edge. After reset the hopper and all stacker counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Channel operation strobe |
| op_code | input | 3 | 0 start, 1 test, 2 test-device, 3 halt, 4 acknowledge |
| stat_vld | output | 1 | Status word valid, one cycle after `op_valid` |
| stat_word | output | 16 | Status returned for the operation |
| ord_req | output | 1 | Sequencer is fetching an order byte |
| ord_ack | input | 1 | Channel presents an order byte |
| ord_byte | input | 8 | Order byte |
| uen | output | 1 | Unusual-end pulse |
| xfer_active | output | 1 | Card data transfer in progress |
| auto_mode | output | 1 | Translated (1) or binary (0) conversion |
| stk_sel | output | 2 | Selected stacker index |
| dp_done | input | 1 | Datapath finished the card |
| dp_err | input | 1 | Datapath saw bad punch data with `dp_done` |
| chain_in | input | 1 | Channel requests command chaining at card end |
| chan_end | output | 1 | Channel-end pulse as a card is retired |
| irq | output | 1 | Interrupt request |
| hop_load | input | 1 | Load the hopper count |
| hop_value | input | HOP_W | Hopper count to load |
| hopper | output | HOP_W | Cards left in the hopper |
| stk_cnt | output | 3*CNT_W | Stacker counts, index 0 in the low field |

## Verification
The assertions assume a channel that behaves within these limits:
- `ord_ack` is raised only while `ord_req` is high.
- `dp_done` comes only while `xfer_active` is high.
- `hop_load` is not driven in the same cycle a card is retired.
- Only one operation is strobed per cycle.

The stimulus stays inside these limits by construction. Every handshake task waits for the matching request output before it drives a response. Random order bytes cover the whole 8-bit space, so legal and illegal codes are both exercised. Chaining and error flags are drawn at random, and hopper loads are issued only while the sequencer is idle.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int STW = 16;

  localparam logic [2:0] OP_START = 3'd0;
  localparam logic [2:0] OP_TEST  = 3'd1;
  localparam logic [2:0] OP_TDEV  = 3'd2;
  localparam logic [2:0] OP_HALT  = 3'd3;
  localparam logic [2:0] OP_ACK   = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_END} crd_state_e;

  function automatic logic order_ok(input logic [7:0] o);
    return (o[7:6] == 2'b00) && (o[1:0] == 2'b10) && (o[5:4] != 2'b10);
  endfunction

  function automatic logic [1:0] stacker_of(input logic [7:0] o);
    case (o[5:4])
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [STW-1:0] test_word(input logic att, input logic busy);
    logic [STW-1:0] w;
    w      = '0;
    w[7]   = att;
    w[6]   = busy;
    w[5]   = busy;
    w[9:8] = busy ? 2'b10 : 2'b00;
    return w;
  endfunction

  function automatic logic [STW-1:0] tdev_word(input logic att, input logic [7:0] ust);
    return att ? {8'h00, ust} : 16'h0200;
  endfunction
endpackage

// File: rtl/crd_order_check.sv
module crd_order_check (
  input  logic [7:0] ord_byte,
  output logic       legal,
  output logic [1:0] stk,
  output logic       mode
);
  import crd_pkg::*;
  always_comb begin
    legal = order_ok(ord_byte);
    stk   = stacker_of(ord_byte);
    mode  = ord_byte[2];
  end
endmodule

// File: rtl/crd_counters.sv
module crd_counters #(
  parameter int HOP_W = 12,
  parameter int CNT_W = 8,
  parameter int NSTK  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [HOP_W-1:0]      load_val,
  input  logic                  bump,
  input  logic [1:0]            sel,
  output logic [HOP_W-1:0]      hopper,
  output logic [NSTK*CNT_W-1:0] stk_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    hopper <= '0;
    else if (load)                 hopper <= load_val;
    else if (bump && hopper != '0) hopper <= hopper - HOP_W'(1);
  end

  for (genvar i = 0; i < NSTK; i++) begin : g_stk
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (bump && sel == 2'(i))   cnt <= cnt + CNT_W'(1);
    end
    assign stk_cnt[i*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/crd_status.sv
module crd_status (
  input  logic [2:0]  op_code,
  input  logic        attached,
  input  logic        busy,
  input  logic [7:0]  unit_stat,
  output logic [15:0] word
);
  import crd_pkg::*;
  always_comb begin
    case (op_code)
      OP_START, OP_TEST, OP_HALT: word = test_word(attached, busy);
      OP_TDEV:                    word = tdev_word(attached, unit_stat);
      default:                    word = '0;
    endcase
  end
endmodule

// File: rtl/crd_order_ctrl.sv
module crd_order_ctrl #(
  parameter int HOP_W = 12,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [2:0]         op_code,
  output logic               stat_vld,
  output logic [15:0]        stat_word,
  output logic               ord_req,
  input  logic               ord_ack,
  input  logic [7:0]         ord_byte,
  output logic               uen,
  output logic               xfer_active,
  output logic               auto_mode,
  output logic [1:0]         stk_sel,
  input  logic               dp_done,
  input  logic               dp_err,
  input  logic               chain_in,
  output logic               chan_end,
  output logic               irq,
  input  logic               hop_load,
  input  logic [HOP_W-1:0]   hop_value,
  output logic [HOP_W-1:0]   hopper,
  output logic [3*CNT_W-1:0] stk_cnt
);
  import crd_pkg::*;
  localparam int NSTK = 3;

  crd_state_e state, state_nx;
  logic       dte_q, mode_q;
  logic [1:0] stk_q;

  // named internal events
  logic attached_w, busy_w, start_ok, halt_kill, ord_take, end_fire, clr_irq;
  logic order_ok_w, order_mode_w;
  logic [1:0] order_stk_w;
  logic [15:0] word_w;

  assign attached_w = (hopper != '0);
  assign busy_w     = (state != S_IDLE);
  assign start_ok   = op_valid && op_code == OP_START && !busy_w && attached_w;
  assign halt_kill  = op_valid && op_code == OP_HALT && busy_w;
  assign clr_irq    = op_valid && (op_code == OP_HALT || op_code == OP_ACK);
  assign ord_take   = (state == S_FETCH) && ord_ack && !halt_kill;
  assign end_fire   = (state == S_END) && !halt_kill;

  crd_order_check u_check (
    .ord_byte (ord_byte),
    .legal    (order_ok_w),
    .stk      (order_stk_w),
    .mode     (order_mode_w)
  );

  crd_status u_status (
    .op_code   (op_code),
    .attached  (attached_w),
    .busy      (busy_w),
    .unit_stat ({4'h0, dte_q, 3'b000}),
    .word      (word_w)
  );

  crd_counters #(.HOP_W(HOP_W), .CNT_W(CNT_W), .NSTK(NSTK)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hop_load),
    .load_val (hop_value),
    .bump     (end_fire),
    .sel      (stk_q),
    .hopper   (hopper),
    .stk_cnt  (stk_cnt)
  );

  always_comb begin
    state_nx = state;
    if (halt_kill) state_nx = S_IDLE;
    else begin
      case (state)
        S_IDLE:  if (start_ok) state_nx = S_FETCH;
        S_FETCH: if (ord_take) state_nx = order_ok_w ? S_XFER : S_IDLE;
        S_XFER:  if (dp_done)  state_nx = S_END;
        default: state_nx = chain_in ? S_FETCH : S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      stk_q     <= '0;
      mode_q    <= 1'b0;
      dte_q     <= 1'b0;
      uen       <= 1'b0;
      chan_end  <= 1'b0;
      irq       <= 1'b0;
      stat_vld  <= 1'b0;
      stat_word <= '0;
    end else begin
      state    <= state_nx;
      uen      <= halt_kill || (ord_take && !order_ok_w);
      chan_end <= end_fire;
      stat_vld <= op_valid;
      if (op_valid) stat_word <= word_w;
      if (start_ok) begin
        stk_q <= '0;
        dte_q <= 1'b0;
      end
      if (ord_take && order_ok_w) begin
        stk_q  <= order_stk_w;
        mode_q <= order_mode_w;
      end
      if (state == S_XFER && dp_done && dp_err && !halt_kill) dte_q <= 1'b1;
      if (clr_irq) irq <= 1'b0;
      else if ((end_fire && !chain_in) || (ord_take && !order_ok_w)) irq <= 1'b1;
    end
  end

  assign ord_req     = (state == S_FETCH);
  assign xfer_active = (state == S_XFER);
  assign auto_mode   = mode_q;
  assign stk_sel     = stk_q;
endmodule

// File: rtl/crd_order_ctrl_chk.sv
module crd_order_ctrl_chk #(
  parameter int HOP_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [2:0]       op_code,
  input logic             ord_req,
  input logic             ord_ack,
  input logic             order_ok_w,
  input logic             uen,
  input logic             xfer_active,
  input logic             irq,
  input logic             hop_load,
  input logic [HOP_W-1:0] hopper,
  input logic             end_fire,
  input logic             chain_in,
  input logic             stat_vld,
  input logic [15:0]      stat_word,
  input logic             busy_w,
  input logic             attached_w
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd0 && !busy_w && attached_w) |=> ord_req);

  assert_bad_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_req && ord_ack && !order_ok_w && !(op_valid && op_code == 3'd3))
      |=> (uen && !xfer_active && !ord_req));

  assert_hopper_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (end_fire && !hop_load && hopper != '0) |=> (hopper == $past(hopper) - HOP_W'(1)));

  assert_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_fire && chain_in) |=> ord_req);

  assert_halt_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd3 && busy_w) |=> (uen && !ord_req && !xfer_active && !irq));

  assert_busy_cc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1 && busy_w) |=> (stat_vld && stat_word[9:8] == 2'b10));

  assert_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4) |=> (stat_vld && stat_word == 16'h0 && !irq));
endmodule

bind crd_order_ctrl crd_order_ctrl_chk #(.HOP_W(HOP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .ord_req     (ord_req),
  .ord_ack     (ord_ack),
  .order_ok_w  (order_ok_w),
  .uen         (uen),
  .xfer_active (xfer_active),
  .irq         (irq),
  .hop_load    (hop_load),
  .hopper      (hopper),
  .end_fire    (end_fire),
  .chain_in    (chain_in),
  .stat_vld    (stat_vld),
  .stat_word   (stat_word),
  .busy_w      (busy_w),
  .attached_w  (attached_w)
);

// File: tb/crd_order_ctrl_bench.sv
module crd_order_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int HW = 12;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0; logic [2:0] op_code = 0;
  logic stat_vld; logic [15:0] stat_word;
  logic ord_req, ord_ack = 0; logic [7:0] ord_byte = 0;
  logic uen, xfer_active, auto_mode; logic [1:0] stk_sel;
  logic dp_done = 0, dp_err = 0, chain_in = 0;
  logic chan_end, irq, hop_load = 0;
  logic [HW-1:0] hop_value = 0, hopper;
  logic [3*CW-1:0] stk_cnt;

  int checks = 0, fails = 0;
  int m_hop = 0;
  int m_stk [3] = '{0, 0, 0};
  bit m_irq = 0, m_dte = 0, m_busy = 0;

  always #(CLK_P/2) clk = ~clk;

  crd_order_ctrl #(.HOP_W(HW), .CNT_W(CW)) u_crd_order_ctrl (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit legal_b(input logic [7:0] o);
    return ((o & 8'hC3) == 8'h02) && (((o >> 4) & 3) != 2);
  endfunction
  function automatic int stk_b(input logic [7:0] o);
    int f = (o >> 4) & 3;
    return (f == 1) ? 1 : (f == 3) ? 2 : 0;
  endfunction
  function automatic int test_b(input bit att, input bit busy);
    return (att ? 'h80 : 0) + (busy ? ('h200 + 'h40 + 'h20) : 0);
  endfunction

  task automatic do_op(input logic [2:0] c);
    @(negedge clk); op_valid = 1; op_code = c;
    @(negedge clk); op_valid = 0;
  endtask

  task automatic load_hop(input int n);
    @(negedge clk); hop_load = 1; hop_value = HW'(n);
    @(negedge clk); hop_load = 0;
    m_hop = n;
    chk("R11 hopper load", hopper, n);
  endtask

  task automatic start_card();
    bit att = (m_hop != 0);
    do_op(3'd0);
    chk("R1 start status", stat_word, test_b(att, m_busy));
    if (att && !m_busy) begin m_busy = 1; m_dte = 0; end
    chk("R1 fetch state", ord_req, m_busy);
  endtask

  task automatic run_order(input logic [7:0] o, input bit ch, input bit er, output bit again);
    bit ok = legal_b(o);
    int s = stk_b(o);
    again = 0;
    @(negedge clk); ord_ack = 1; ord_byte = o;
    @(negedge clk); ord_ack = 0;
    chk("R2 unusual end on order", uen, !ok);
    if (!ok) begin
      m_irq = 1; m_busy = 0;
      chk("R2 rejected goes idle", xfer_active | ord_req, 0);
      return;
    end
    chk("R2 transfer started", xfer_active, 1);
    chk("R3 stacker select", stk_sel, s);
    chk("R4 mode bit", auto_mode, o[2]);
    chain_in = ch; dp_err = er; dp_done = 1;
    @(negedge clk); dp_done = 0; dp_err = 0;
    @(negedge clk);
    chk("R5 channel end pulse", chan_end, 1);
    if (m_hop > 0) m_hop--;
    m_stk[s] = (m_stk[s] + 1) % 256;
    if (er) m_dte = 1;
    chk("R5 hopper decrement", hopper, m_hop);
    chk("R3 stacker count", stk_cnt[s*CW +: CW], m_stk[s]);
    chk("R6 chain to fetch", ord_req, ch);
    if (!ch) begin m_irq = 1; m_busy = 0; end
    chk("R10 irq after end", irq, m_irq);
    chain_in = 0;
    again = ch;
  endtask

  task automatic card(input logic [7:0] o, input bit ch, input bit er);
    bit again;
    start_card();
    run_order(o, ch, er, again);
    while (again) run_order(8'h02, 0, 0, again);
  endtask

  initial begin
    #(CLK_P * 190000);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit again;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset hopper", hopper, 0);
    chk("R11 reset stackers", stk_cnt, 0);
    chk("R10 reset irq", irq, 0);
    chk("R1 reset idle", ord_req | xfer_active, 0);

    do_op(3'd1); chk("R8 detached test", stat_word, test_b(0, 0));
    do_op(3'd2); chk("R9 detached tdev", stat_word, 'h200);
    start_card();  // detached: refused

    load_hop(300);
    do_op(3'd1); chk("R8 attached idle test", stat_word, test_b(1, 0));

    // directed corner orders
    card(8'h3E, 0, 0);
    card(8'h3F, 0, 0);
    card(8'h22, 0, 0);
    card(8'h42, 0, 0);
    card(8'h16, 1, 1);
    do_op(3'd2); chk("R9 data error bit", stat_word, 'h08);
    do_op(3'd4);
    m_irq = 0;
    chk("R10 ack zero", stat_word, 0);
    chk("R10 ack clears irq", irq, 0);

    // busy status and ignored start
    start_card();
    do_op(3'd1); chk("R8 busy test", stat_word, test_b(1, 1));
    start_card();
    chk("R1 busy start keeps fetch", ord_req, 1);
    do_op(3'd3);
    chk("R7 halt status", stat_word, test_b(1, 1));
    chk("R7 halt uen", uen, 1);
    chk("R7 halt idle", ord_req | irq, 0);
    m_busy = 0; m_irq = 0;
    do_op(3'd3); chk("R7 idle halt no uen", uen, 0);

    // halt during transfer
    start_card();
    @(negedge clk); ord_ack = 1; ord_byte = 8'h06;
    @(negedge clk); ord_ack = 0;
    do_op(3'd3);
    chk("R7 halt in transfer", {uen, xfer_active}, 2'b10);
    m_busy = 0;
    chk("R7 hopper untouched", hopper, m_hop);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] o = 8'($urandom);
      if ($urandom % 2) o = (o & 8'h3C) | 8'h02;
      start_card();
      run_order(o, bit'($urandom % 2), bit'($urandom % 2), again);
      while (again) run_order(8'($urandom) & 8'h3E | 8'h02, bit'($urandom % 3 == 0), 0, again);
      if (m_busy) begin do_op(3'd3); m_busy = 0; m_irq = 0; end
    end
    do_op(3'd2); chk("R9 tdev after random", stat_word, m_dte ? 'h08 : 0);

    // stacker wrap on alternate stacker 2
    load_hop(400);
    for (int i = 0; i < 256; i++) card(8'h32, 0, 0);
    chk("R3 stacker wrap", stk_cnt[2*CW +: CW], m_stk[2]);

    // detach at zero
    load_hop(1);
    card(8'h12, 0, 0);
    chk("R5 detached hopper", hopper, 0);
    do_op(3'd1); chk("R5 auto bit clear", stat_word, test_b(0, 0));
    start_card();
    chk("R5 start refused", ord_req, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule